// File: doc/BRIEF.md
# Linear Systolic Matrix-Vector Multiplier

This block computes y = A·x for an N×N signed integer matrix on a row of N identical cells. Cell i keeps element x_i of the vector in a local register for the whole computation. A running sum moves one cell per clock, from the highest-numbered cell down to cell 0. Each cell adds its product x_i·a to the sum it receives, where a is the coefficient present on its own lane in that beat. The sum entering the last cell is always zero, so a finished row total leaves cell 0.

The matrix is streamed as a burst of 2N−1 beats. Each beat carries one value per lane, and the rows are skewed diagonally: lane i in beat k carries A[j][i] with j = k − (N−1−i). A beat slot that maps to no row is a padding slot. The block masks padding slots itself, so the caller may place any value there. Once the pipeline is full, one element of y comes out per beat, together with a valid flag. The vector is loaded as one parallel word between bursts.

Top module: `sysmv_array`

## Requirements
- R1: While rst_ni is low and after it is released, y_valid_o is 0 and y_data_o is 0. The partial sums, the beat counter, the valid flag and the stored vector are all cleared.
- R2: Row result y_j equals the signed sum over i of A[j][i]·x_i. It appears on y_data_o in the cycle after burst beat N−1+j.
- R3: A burst is 2N−1 beats, marked by a_valid_i high. In beat k, lane i (bits [i*DATA_W +: DATA_W] of a_lanes_i) carries A[k−(N−1−i)][i].
- R4: The value on a lane in a beat where k−(N−1−i) lies outside 0..N−1 has no effect on any result.
- R5: y_valid_o is high in the cycle after burst beats N−1 through 2N−2 and low otherwise. The first valid cycle therefore comes N−1 clocks after the first beat is taken, and a burst with no gaps gives exactly N valid cycles.
- R6: A cycle with a_valid_i low mid-burst stalls the array. No sum advances, y_valid_o is 0 in the following cycle, and y_data_o keeps its value.
- R7: When x_load_i is high and the array is idle, x_vec_i is stored: lane i at bits [i*DATA_W +: DATA_W] goes to cell i. Idle means the beat counter is at 0 and a_valid_i is low. A load request in any other cycle is ignored.
- R8: Operands are 8-bit two's complement and sums are 20-bit two's complement, so the extreme case of all operands at −128 gives 3·16384 = 49152 without overflow.
- R9: A new burst may start in the beat right after the last beat of the previous one, and both give correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register updates on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| x_load_i | input | 1 | Request to store x_vec_i into the cells |
| x_vec_i | input | N_CELLS*DATA_W | Vector operand, lane i for cell i, signed |
| a_valid_i | input | 1 | Current beat of a_lanes_i is a burst beat |
| a_lanes_i | input | N_CELLS*DATA_W | Skewed matrix coefficients, one signed lane per cell |
| y_valid_o | output | 1 | y_data_o holds a finished row result |
| y_data_o | output | ACC_W | Signed sum leaving cell 0 |

## Verification
The bench fills the padding slots with nonzero garbage. A design that trusts the caller to zero-pad would then fold stray products into the row totals. It inserts a stall inside a burst and raises a load request during that stall and during a live beat. A design that kept advancing, or that accepted the load, would shift the outputs or mix two vectors into one result. Back-to-back bursts check that the beat counter wraps without a lost beat. All-negative extreme operands catch a product or sum that is truncated or sign-extended wrongly.

// File: rtl/sysmv_pkg.sv
package sysmv_pkg;

  // Lane i of beat k carries a real coefficient when its row index is in range.
  function automatic logic lane_in_band(int beat, int lane, int n);
    int row;
    row = beat - (n - 1 - lane);
    return (row >= 0) && (row <= n - 1);
  endfunction

  function automatic int beat_cnt_w(int n);
    return (2 * n - 1) > 1 ? $clog2(2 * n - 1) : 1;
  endfunction

endpackage

// File: rtl/sysmv_seq.sv
module sysmv_seq
  import sysmv_pkg::*;
#(
  parameter int N_CELLS = 3,
  localparam int CW = beat_cnt_w(N_CELLS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_valid_i,
  output logic [CW-1:0] cnt_o,
  output logic          load_ok_o,
  output logic          y_valid_o
);

  localparam logic [CW-1:0] LAST = CW'(2 * N_CELLS - 2);

  logic [CW-1:0] cnt_q;
  logic          y_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      y_valid_q <= 1'b0;
    end else begin
      y_valid_q <= a_valid_i && (int'(cnt_q) >= N_CELLS - 1);
      if (a_valid_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign load_ok_o = (cnt_q == '0) && !a_valid_i;
  assign y_valid_o = y_valid_q;

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  // R9
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && cnt_q == LAST) |=> cnt_q == '0);

  // R5
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_q |-> $past(a_valid_i));

endmodule

// File: rtl/sysmv_cell.sv
module sysmv_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ld_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic                     en_i,
  input  logic                     band_i,
  input  logic signed [DATA_W-1:0] a_i,
  input  logic signed [ACC_W-1:0]  sum_i,
  output logic signed [ACC_W-1:0]  sum_o,
  output logic signed [DATA_W-1:0] x_o
);

  logic signed [DATA_W-1:0]   x_q;
  logic signed [ACC_W-1:0]    s_q;
  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    term;

  assign prod = x_q * a_i;
  // padding slots contribute nothing regardless of lane content
  assign term = band_i ? ACC_W'(prod) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      s_q <= '0;
    end else begin
      if (ld_i) x_q <= x_i;
      if (en_i) s_q <= sum_i + term;
    end
  end

  assign sum_o = s_q;
  assign x_o   = x_q;

  // R6
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(s_q));

endmodule

// File: rtl/sysmv_array.sv
module sysmv_array
  import sysmv_pkg::*;
#(
  parameter int N_CELLS = 3,
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 20
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        x_load_i,
  input  logic [N_CELLS*DATA_W-1:0]   x_vec_i,
  input  logic                        a_valid_i,
  input  logic [N_CELLS*DATA_W-1:0]   a_lanes_i,
  output logic                        y_valid_o,
  output logic signed [ACC_W-1:0]     y_data_o
);

  localparam int CW = beat_cnt_w(N_CELLS);

  logic [CW-1:0]              cnt;
  logic                       load_ok;
  logic                       ld;
  logic signed [ACC_W-1:0]    sum_w [N_CELLS+1];
  logic [N_CELLS*DATA_W-1:0]  x_all;

  sysmv_seq #(.N_CELLS(N_CELLS)) seq_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .a_valid_i (a_valid_i),
    .cnt_o     (cnt),
    .load_ok_o (load_ok),
    .y_valid_o (y_valid_o)
  );

  assign ld             = x_load_i && load_ok;
  assign sum_w[N_CELLS] = '0;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic band;
    assign band = lane_in_band(int'(cnt), i, N_CELLS);

    sysmv_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) cell_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (ld),
      .x_i    (x_vec_i[i*DATA_W +: DATA_W]),
      .en_i   (a_valid_i),
      .band_i (band),
      .a_i    (a_lanes_i[i*DATA_W +: DATA_W]),
      .sum_i  (sum_w[i+1]),
      .sum_o  (sum_w[i]),
      .x_o    (x_all[i*DATA_W +: DATA_W])
    );
  end

  assign y_data_o = sum_w[0];

  // R7
  x_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_ok |=> $stable(x_all));

  // R6
  y_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !a_valid_i |=> ($stable(y_data_o) && !y_valid_o));

endmodule

// File: tb/sysmv_array_tb.sv
`timescale 1ns/1ps
module sysmv_array_tb_top;

  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 20;
  localparam int NB = 2 * N - 1;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic                 x_load_i = 1'b0;
  logic [N*DW-1:0]      x_vec_i = '0;
  logic                 a_valid_i = 1'b0;
  logic [N*DW-1:0]      a_lanes_i = '0;
  logic                 y_valid_o;
  logic signed [AW-1:0] y_data_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  int am [2][N][N];
  int xv [N];
  int ye [2][N];

  always #4 clk = ~clk;

  sysmv_array #(.N_CELLS(N), .DATA_W(DW), .ACC_W(AW)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .x_load_i  (x_load_i),
    .x_vec_i   (x_vec_i),
    .a_valid_i (a_valid_i),
    .a_lanes_i (a_lanes_i),
    .y_valid_o (y_valid_o),
    .y_data_o  (y_data_o)
  );

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_x(int v0, int v1, int v2);
    @(negedge clk);
    x_load_i = 1'b1;
    x_vec_i  = {DW'(v2), DW'(v1), DW'(v0)};
    xv[0] = v0; xv[1] = v1; xv[2] = v2;
    @(negedge clk);
    x_load_i = 1'b0;
  endtask

  // Streams nb bursts; optional garbage in padding, one stall, load attempts.
  task automatic run(string req, int nb, bit junk, int gap_at, bit try_load);
    int  k = 0;
    int  pk = 0;
    bit  pbeat = 1'b0;
    bit  gapped = 1'b0;
    bit  first = 1'b1;
    int  last_y = 0;
    for (int b = 0; b < nb; b++)
      for (int j = 0; j < N; j++) begin
        ye[b][j] = 0;
        for (int i = 0; i < N; i++) ye[b][j] += am[b][j][i] * xv[i];
      end
    for (int cyc = 0; cyc < 4 * NB * nb; cyc++) begin
      @(negedge clk);
      if (pbeat) begin
        int kb = pk % NB;
        int bb = pk / NB;
        chk({req, " R5 valid"}, int'(y_valid_o), (kb >= N - 1) ? 1 : 0);
        if (kb >= N - 1) chk({req, " R2 data"}, int'(y_data_o), ye[bb][kb-(N-1)]);
      end else if (!first) begin
        chk({req, " R6 stall valid"}, int'(y_valid_o), 0);
        chk({req, " R6 stall data"}, int'(y_data_o), last_y);
      end
      first  = 1'b0;
      last_y = int'(y_data_o);
      x_load_i = 1'b0;
      if (k >= nb * NB) break;
      if (k == gap_at && !gapped) begin
        gapped    = 1'b1;
        a_valid_i = 1'b0;
        a_lanes_i = {N*DW{1'b1}};
        pbeat     = 1'b0;
        if (try_load) begin x_load_i = 1'b1; x_vec_i = {N{8'sd77}}; end
      end else begin
        int kb = k % NB;
        int bb = k / NB;
        a_valid_i = 1'b1;
        for (int i = 0; i < N; i++) begin
          int row = kb - (N - 1 - i);
          int v   = (row >= 0 && row < N) ? am[bb][row][i] : (junk ? 37 * (i + 1) - kb * 11 : 0);
          a_lanes_i[i*DW +: DW] = DW'(v);
        end
        if (try_load && kb == 2) begin x_load_i = 1'b1; x_vec_i = {N{8'sd99}}; end
        pbeat = 1'b1;
        pk    = k;
        k++;
      end
    end
    a_valid_i = 1'b0;
    x_load_i  = 1'b0;
    @(negedge clk);
    chk({req, " R5 idle valid"}, int'(y_valid_o), 0);
  endtask

  task automatic set_mat(int b, int base, int step);
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++) am[b][j][i] = base + step * (j * N + i) - 4 * ((i + j) % 2);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(y_valid_o), 0);
    chk("R1 data in reset", int'(y_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", int'(y_valid_o), 0);
    chk("R1 data after reset", int'(y_data_o), 0);
  endtask

  task automatic t_basic();
    load_x(3, -2, 5);
    set_mat(0, 1, 2);
    run("R2 R3 basic", 1, 1'b0, -1, 1'b0);
  endtask

  task automatic t_junk();
    set_mat(0, -7, 3);
    run("R4 padding junk", 1, 1'b1, -1, 1'b0);
  endtask

  task automatic t_stall_load();
    set_mat(0, 4, -1);
    run("R6 R7 stall and busy load", 1, 1'b1, 3, 1'b1);
  endtask

  task automatic t_reload();
    load_x(-9, 11, 1);
    set_mat(0, 2, 5);
    run("R7 idle load", 1, 1'b0, -1, 1'b0);
  endtask

  task automatic t_extreme();
    load_x(-128, -128, -128);
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++) am[0][j][i] = (j == 2) ? 127 : -128;
    am[0][1][1] = 0;
    run("R8 extremes", 1, 1'b1, -1, 1'b0);
  endtask

  task automatic t_back_to_back();
    load_x(6, -3, 2);
    set_mat(0, -5, 4);
    set_mat(1, 9, -3);
    run("R9 back to back", 2, 1'b1, -1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_junk();
    t_stall_load();
    t_reload();
    t_extreme();
    t_back_to_back();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog (all): actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule